// File: doc/BRIEF.md
# Symmetric Linear-Phase Correction Filter

This block is a linear-phase FIR equalizer that sits on the interleaved output stream of a multichannel oversampling converter. It flattens the passband ripple that the comb-based reconstruction leaves behind. The impulse response is symmetric, so each pair of mirrored delay-line samples is summed before it meets its coefficient. Roughly half the multipliers are therefore needed. Coefficients are small signed constants written through a plain register port.

To keep the datapath narrow, the result is rounded in two places. Each product is rounded to a coarser grid before the adder tree, and the finished sum is rounded again and clipped to the output word. The cut before the adder tree is the larger of the two. The delay is fixed by the pipeline, so every channel sharing the stream sees the same group delay.

Both data sides use valid/ready. An input is taken on a clock edge where `in_valid` and `in_ready` are both high. An output is taken on an edge where `out_valid` and `out_ready` are both high. The whole pipeline advances together, and only when the output register is empty or being drained, so `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. A producer may hold `in_valid` low for any number of cycles. Coefficient writes must be issued only while no sample is in flight.

Top module: `cfir_sym_eq`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1, and the delay line holds zeros, so the first outputs are computed as if all earlier samples were 0.
- R2: With NT = `NTAPS` taps (defaults 11; 15 also supported), let x[j] be the j-th most recent accepted sample (x[0] newest) and let c[k] be coefficient k. For each k below NT/2 (integer division), the product term is c[k]·(x[k] + x[NT−1−k]).
- R3: When NT is odd, coefficient index (NT−1)/2 multiplies x[(NT−1)/2] alone, with no partner sample added.
- R4: Each product term is rounded by adding 2^(`DROP1`−1) and discarding `DROP1` LSBs (floor), before it is summed (default `DROP1` = 6).
- R5: The sum of the rounded terms is rounded by adding 2^(`DROP2`−1) and discarding `DROP2` LSBs (default `DROP2` = 2, with `DROP1` ≥ `DROP2`).
- R6: The rounded sum is clipped to the signed `OW`-bit range (2047 and −2048 by default) rather than wrapping.
- R7: A write with `cfg_we` = 1 stores the 8-bit two's-complement `cfg_data` into coefficient `cfg_addr` (0 … (NT+1)/2 − 1) at that clock edge. It applies to every sample accepted after the write.
- R8: With `out_ready` held high, a sample accepted at clock edge e appears with `out_valid` = 1 after edge e+2. The output handshake is therefore three cycles after the input handshake.
- R9: While `out_valid` = 1 and `out_ready` = 0, `out_valid` and `out_data` hold and `in_ready` = 0. Outputs leave in input order with none lost or repeated.
- R10: Cycles with `in_valid` = 0 do not shift the delay line; only accepted samples enter it.
- R11: A write with `cfg_addr` ≥ (NT+1)/2 changes no coefficient.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Filter can take a sample this cycle |
| in_data | input | DW (12) | Signed input sample |
| out_valid | output | 1 | Filtered sample offered |
| out_ready | input | 1 | Consumer takes the sample this cycle |
| out_data | output | OW (12) | Signed filtered, rounded, clipped sample |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_addr | input | CAW (3) | Coefficient index |
| cfg_data | input | CW (8) | Signed coefficient value |

## Verification
The hardest case to reach from the ports is the interaction of stalls and bubbles with the delay line. If a stall wrongly shifted the taps, or a bubble entered them, the error would appear only several samples later, mixed into a weighted sum. The stimulus runs a long pseudo-random stream with independent random gaps on `in_valid` and random drops of `out_ready`. A reference delay line in the bench advances only on observed handshakes. Every output is compared exactly, so a stray shift corrupts the following sums. The rounding boundaries are reached by sweeping small inputs through a single unit coefficient on the centre tap and on an outer pair. Clipping in both directions is reached by filling the line with full-scale samples under extreme coefficients.

// File: rtl/cfir_pkg.sv
package cfir_pkg;
  // number of mirrored pairs that share one multiplier
  function automatic int pair_count(input int nt);
    return nt / 2;
  endfunction

  // number of stored coefficients (pairs plus optional centre)
  function automatic int coef_count(input int nt);
    return (nt + 1) / 2;
  endfunction
endpackage

// File: rtl/cfir_tapline.sv
module cfir_tapline #(
  parameter int NT = 11,
  parameter int DW = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   shift,
  input  logic [DW-1:0]          din,
  output logic [NT-1:0][DW-1:0]  taps
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taps <= '0;
    end else if (shift) begin
      taps[0] <= din;
      for (int i = 1; i < NT; i++) taps[i] <= taps[i-1];
    end
  end

  // R10: delay line only moves on an accepted sample
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !shift |=> $stable(taps));
endmodule

// File: rtl/cfir_fold_mac.sv
module cfir_fold_mac #(
  parameter int NT    = 11,
  parameter int DW    = 12,
  parameter int CW    = 8,
  parameter int DROP1 = 6,
  parameter int NC    = cfir_pkg::coef_count(NT),
  parameter int RW    = DW + 1 + CW - DROP1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en,
  input  logic [NT-1:0][DW-1:0]  taps,
  input  logic [NC-1:0][CW-1:0]  coefs,
  output logic [NC-1:0][RW-1:0]  terms
);
  localparam int NP = cfir_pkg::pair_count(NT);
  localparam int PW = DW + 1 + CW;

  for (genvar k = 0; k < NC; k++) begin : g_term
    logic signed [DW:0]   pre;
    logic signed [CW-1:0] cf;
    logic signed [PW-1:0] prod;
    logic        [RW-1:0] rnd;

    if (k < NP) begin : g_pair
      assign pre = $signed({taps[k][DW-1], taps[k]})
                 + $signed({taps[NT-1-k][DW-1], taps[NT-1-k]});
    end else begin : g_mid
      assign pre = $signed({taps[k][DW-1], taps[k]});
    end

    assign cf   = $signed(coefs[k]);
    assign prod = pre * cf;

    if (DROP1 > 0) begin : g_rnd
      logic [PW-1:0] biased;
      assign biased = prod + PW'(2 ** (DROP1 - 1));
      assign rnd    = biased[PW-1:DROP1];
    end else begin : g_raw
      assign rnd = prod;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  terms[k] <= '0;
      else if (en) terms[k] <= rnd;
    end
  end
endmodule

// File: rtl/cfir_sum_sat.sv
module cfir_sum_sat #(
  parameter int NC    = 6,
  parameter int RW    = 15,
  parameter int DROP2 = 2,
  parameter int OW    = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en,
  input  logic                   v_in,
  input  logic                   out_ready,
  input  logic [NC-1:0][RW-1:0]  terms,
  output logic                   out_valid,
  output logic [OW-1:0]          out_data
);
  localparam int SW = RW + $clog2(NC + 1) + 1;
  localparam int AW = SW - DROP2;
  localparam logic [AW-1:0] HI = {{(AW-OW+1){1'b0}}, {(OW-1){1'b1}}};
  localparam logic [AW-1:0] LO = ~HI;

  logic [SW-1:0] acc;
  logic [AW-1:0] rnd;
  logic [OW-1:0] sat;

  always_comb begin
    acc = '0;
    for (int i = 0; i < NC; i++) acc = acc + SW'($signed(terms[i]));
  end

  if (DROP2 > 0) begin : g_rnd
    logic [SW-1:0] biased;
    assign biased = acc + SW'(2 ** (DROP2 - 1));
    assign rnd    = biased[SW-1:DROP2];
  end else begin : g_raw
    assign rnd = acc;
  end

  always_comb begin
    if ($signed(rnd) > $signed(HI))      sat = HI[OW-1:0];
    else if ($signed(rnd) < $signed(LO)) sat = LO[OW-1:0];
    else                                 sat = rnd[OW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (en) begin
      out_valid <= v_in;
      if (v_in) out_data <= sat;
    end
  end

  // R9: a stalled output holds its value
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R6: clipping at the top of the range
  a_r6_clip_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (en && v_in && $signed(rnd) > $signed(HI)) |=> (out_data == HI[OW-1:0]));
endmodule

// File: rtl/cfir_sym_eq.sv
module cfir_sym_eq #(
  parameter int NTAPS = 11,
  parameter int DW    = 12,
  parameter int CW    = 8,
  parameter int DROP1 = 6,
  parameter int DROP2 = 2,
  parameter int OW    = 12,
  parameter int NC    = cfir_pkg::coef_count(NTAPS),
  parameter int CAW   = (NC > 1) ? $clog2(NC + 1) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [DW-1:0]   in_data,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [OW-1:0]   out_data,
  input  logic            cfg_we,
  input  logic [CAW-1:0]  cfg_addr,
  input  logic [CW-1:0]   cfg_data
);
  localparam int RW = DW + 1 + CW - DROP1;

  logic                      en, fire, v0, v1;
  logic [NTAPS-1:0][DW-1:0]  taps;
  logic [NC-1:0][CW-1:0]     coefs;
  logic [NC-1:0][RW-1:0]     terms;

  assign en       = !out_valid || out_ready;
  assign in_ready = en;
  assign fire     = in_valid && en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v0 <= 1'b0;
      v1 <= 1'b0;
    end else if (en) begin
      v0 <= in_valid;
      v1 <= v0;
    end
  end

  for (genvar k = 0; k < NC; k++) begin : g_coef
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) coefs[k] <= '0;
      else if (cfg_we && cfg_addr == CAW'(k)) coefs[k] <= cfg_data;
    end

    // R7: an addressed write lands in its coefficient
    a_r7_write: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_addr == CAW'(k)) |=> (coefs[k] == $past(cfg_data)));
  end

  cfir_tapline #(.NT(NTAPS), .DW(DW)) u_line (
    .clk(clk), .rst_n(rst_n), .shift(fire), .din(in_data), .taps(taps));

  cfir_fold_mac #(.NT(NTAPS), .DW(DW), .CW(CW), .DROP1(DROP1), .NC(NC), .RW(RW)) u_mac (
    .clk(clk), .rst_n(rst_n), .en(en), .taps(taps), .coefs(coefs), .terms(terms));

  cfir_sum_sat #(.NC(NC), .RW(RW), .DROP2(DROP2), .OW(OW)) u_sum (
    .clk(clk), .rst_n(rst_n), .en(en), .v_in(v1), .out_ready(out_ready),
    .terms(terms), .out_valid(out_valid), .out_data(out_data));

  // R8: an advancing pipeline with a sample in the product stage presents it next
  a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (en && v1) |=> out_valid);

  // R9: no input is taken while the output is stalled
  a_r9_no_take: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

// File: tb/cfir_sym_eq_tb.sv
module cfir_sym_eq_tb;
  localparam int NT = 11, DW = 12, CW = 8, D1 = 6, D2 = 2, OW = 12;
  localparam int NC = (NT + 1) / 2, CAW = 3;
  localparam int MAXO = 2 ** (OW - 1) - 1, MINO = -(2 ** (OW - 1));

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, out_ready = 0, cfg_we = 0;
  logic [DW-1:0] in_data = '0;
  logic [CAW-1:0] cfg_addr = '0;
  logic [CW-1:0] cfg_data = '0;
  logic in_ready, out_valid;
  logic [OW-1:0] out_data;

  always #2.5 clk = ~clk;

  cfir_sym_eq #(.NTAPS(NT), .DW(DW), .CW(CW), .DROP1(D1), .DROP2(D2), .OW(OW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data));

  int checks = 0, errors = 0, cyc = 0, wr = 0, rd = 0, seed = 7;
  int hist[NT];
  int c[NC];
  int exp_q[8192];
  int acc_cyc[8192];
  bit lat_chk = 0, done = 0, held = 0;
  int held_val = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic int model();
    int s = 0;
    for (int k = 0; k < NT / 2; k++) s += ((hist[k] + hist[NT-1-k]) * c[k] + 2 ** (D1 - 1)) >>> D1;
    s += (hist[NC-1] * c[NC-1] + 2 ** (D1 - 1)) >>> D1;
    s = (s + 2 ** (D2 - 1)) >>> D2;
    if (s > MAXO) s = MAXO;
    if (s < MINO) s = MINO;
    return s;
  endfunction

  function automatic int rnd();
    seed = seed * 1103515245 + 12345;
    return (seed >>> 8) & 32'h7fff;
  endfunction

  task automatic step(input bit iv, input int d, input bit ordy, input string tag);
    @(negedge clk);
    in_valid = iv; in_data = d[DW-1:0]; out_ready = ordy; cfg_we = 0;
    #1;
    chk(in_ready == (!out_valid || out_ready), "R9 ready rule", int'(in_ready), int'(!out_valid || out_ready));
    if (held && out_valid)
      chk($signed(out_data) == held_val, "R9 hold", $signed(out_data), held_val);
    held = out_valid && !out_ready;
    held_val = $signed(out_data);
    if (in_valid && in_ready) begin
      for (int j = NT - 1; j > 0; j--) hist[j] = hist[j-1];
      hist[0] = d;
      exp_q[wr] = model(); acc_cyc[wr] = cyc; wr++;
    end
    if (out_valid && out_ready) begin
      chk($signed(out_data) == exp_q[rd], tag, $signed(out_data), exp_q[rd]);
      if (lat_chk) chk(cyc - acc_cyc[rd] == 3, "R8 latency", cyc - acc_cyc[rd], 3);
      rd++;
    end
    cyc++;
  endtask

  task automatic drain();
    for (int i = 0; i < 6; i++) step(0, 0, 1, "drain");
  endtask

  task automatic wcoef(input int a, input int v);
    @(negedge clk);
    in_valid = 0; out_ready = 1; cfg_we = 1; cfg_addr = a[CAW-1:0]; cfg_data = v[CW-1:0];
    if (a < NC) c[a] = v;  // R7; addresses at or above NC change nothing (R11)
    cyc++;
    @(negedge clk);
    cfg_we = 0; cyc++;
  endtask

  task automatic setall(input int v);
    for (int k = 0; k < NC; k++) wcoef(k, v);
  endtask

  initial begin
    #(5 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int j = 0; j < NT; j++) hist[j] = 0;
    for (int k = 0; k < NC; k++) c[k] = 0;
    #1;
    chk(out_valid == 0, "R1 reset valid", int'(out_valid), 0);
    chk(in_ready == 1, "R1 reset ready", int'(in_ready), 1);
    #12 rst_n = 1;

    // R1, R2: generic coefficients, fresh zero history, full-scale sweep
    wcoef(0, 3); wcoef(1, -5); wcoef(2, 10); wcoef(3, -20); wcoef(4, 40); wcoef(5, 100);
    lat_chk = 1;
    for (int x = -2048; x < 2048; x += 7) step(1, x, 1, "R2 sweep");
    drain();

    // R3, R4, R5: centre tap alone at unit weight, rounding boundaries
    setall(0); wcoef(NC - 1, 1);
    for (int x = -300; x <= 300; x++) step(1, x, 1, "R3 R4 R5 centre");
    drain();

    // R2, R4: one outer pair alone
    setall(0); wcoef(0, 1);
    for (int x = -300; x <= 300; x++) step(1, x, 1, "R2 R4 pair");
    drain();

    // R6: clipping in both directions
    setall(127);
    for (int i = 0; i < 14; i++) step(1, 2047, 1, "R6 high");
    for (int i = 0; i < 14; i++) step(1, -2048, 1, "R6 low");
    drain();
    chk($signed(out_data) == MINO, "R6 low value", $signed(out_data), MINO);
    setall(-128);
    for (int i = 0; i < 14; i++) step(1, -2048, 1, "R6 neg coef");
    drain();
    chk($signed(out_data) == MAXO, "R6 high value", $signed(out_data), MAXO);

    // R9, R10: random bubbles and back-pressure
    lat_chk = 0;
    wcoef(0, -7); wcoef(1, 12); wcoef(2, -33); wcoef(3, 64); wcoef(4, -90); wcoef(5, 127);
    for (int i = 0; i < 1500; i++)
      step((rnd() % 10) < 7, (rnd() % 4096) - 2048, (rnd() % 10) < 6, "R9 R10 stream");
    drain();

    // R11: writes beyond the coefficient range are ignored
    wcoef(NC, 99); wcoef(NC + 1, -99);
    lat_chk = 1;
    for (int i = 0; i < 200; i++) step(1, (rnd() % 4096) - 2048, 1, "R11 ignored write");
    drain();

    chk(rd == wr, "R9 count", rd, wr);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule